// File: doc/BRIEF.md
# UART Host Register Front-End with Receive Queue

This block is the processor-facing side of a UART. A simple word-addressed register port gives software access to a receive queue, status flags, interrupt state and a set of configuration registers. Received characters arrive on a byte-stream input with a valid/ready handshake. Characters that software writes to the data register leave on a byte-stream output as a one-cycle pulse. The serialiser, the baud generator and DMA sit outside; the divisor, low-power and DMA registers are storage only.

The receive queue holds up to 16 bytes when the queue-enable bit of line control is set. When that bit is clear it behaves as a single holding register. Status flags are updated on every push and every pop. A receive interrupt is raised when a push brings the stored count up to the trigger level of one, and it drops when a read brings the count back to zero. A transmit interrupt is raised by each data write. Both can be cleared by software. One combined interrupt output is asserted whenever a raw interrupt is set and its mask bit is also set. A small read-only window near the top of the 4 KB space returns eight identification bytes.

Top module: `uart_fe_top`

## Requirements
- R1: After reset, flags (word 6) read 0x90, control (word 12) reads 0x300, level select (word 13) reads 0x12, raw status (word 15) reads 0 and `irq` is 0.
- R2: The configuration registers read back what was written, limited to their widths. These are low-power divisor (word 8, 8 bits), integer divisor (word 9, 16 bits), fractional divisor (word 10, 6 bits), line control (word 11, 8 bits), control (word 12, 16 bits), level select (word 13, 6 bits), interrupt mask (word 14, 11 bits) and DMA control (word 18, 3 bits).
- R3: `rx_ready` is high only while fewer than 16 bytes are stored when line control bit 4 is 1, or while no byte is stored when it is 0. A byte is taken in any cycle where `rx_valid` and `rx_ready` are both high.
- R4: A read of word 0 returns the oldest stored byte in bits 7:0 and removes it, so bytes come out in arrival order across wrap-around of the 16-entry ring. A read of word 0 while the queue is empty removes nothing.
- R5: In the flags word, bit 7 (transmit empty) always reads 1 and bit 5 (transmit full) always reads 0. Bit 4 (receive empty) clears on a push and sets when a read empties the queue. Bit 6 (receive full) sets on a push that makes the count 16, or on any push while control bit 4 is 1, and clears on every read of word 0.
- R6: Raw status bit 4 (receive) sets when a push brings the count to 1. It clears when a read of word 0 brings the count to 0.
- R7: A write of word 0 sends bits 7:0 on `tx_byte` with `tx_valid` high for exactly one cycle, starting the cycle after the write. It also sets raw status bit 5 (transmit).
- R8: A write of word 17 clears each raw status bit whose written bit is 1 and leaves the other bits unchanged.
- R9: Masked status (word 16) reads raw status ANDed with the mask. `irq` is high exactly when the masked status is nonzero, and it changes in the same cycle as the state that causes it.
- R10: Byte addresses 0xFE0, 0xFE4 … 0xFFC read 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R11: Unmapped word offsets read 0. Writes to the flags, raw status and masked status words have no effect.
- R12: `bus_rvalid` is high exactly one cycle after each cycle with `bus_rd` high, and `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the 4 KB space |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Queue can take a byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | One-cycle transmit pulse |
| irq | output | 1 | Combined interrupt |

## Verification
Every result of this block is due one clock edge after its cause. Read data and `bus_rvalid` appear one cycle after the read strobe. The transmit pulse appears one cycle after the data write. Flags, raw status and `irq` take their new value at the same edge that accepts a push or performs a pop. The bench drives all stimulus on the falling edge and samples on the next falling edge, half a cycle after the edge that produced the result. Expected read and transmit values go into scoreboard queues that a monitor drains when `bus_rvalid` or `tx_valid` rises. `irq` and `rx_ready` are sampled directly, on the falling edge right after the causing operation.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  // Word offsets (byte address bits 11:2)
  localparam int WO_DATA  = 0;
  localparam int WO_FLAG  = 6;
  localparam int WO_LPDIV = 8;
  localparam int WO_IDIV  = 9;
  localparam int WO_FDIV  = 10;
  localparam int WO_LINE  = 11;
  localparam int WO_CTRL  = 12;
  localparam int WO_LVL   = 13;
  localparam int WO_MASK  = 14;
  localparam int WO_RAW   = 15;
  localparam int WO_MSTAT = 16;
  localparam int WO_ICLR  = 17;
  localparam int WO_DMA   = 18;

  // Stored register widths
  localparam int LPDIV_W = 8;
  localparam int IDIV_W  = 16;
  localparam int FDIV_W  = 6;
  localparam int LINE_W  = 8;
  localparam int CTRL_W  = 16;
  localparam int LVL_W   = 6;
  localparam int MASK_W  = 11;
  localparam int DMA_W   = 3;

  // Reset values
  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
  localparam logic [LVL_W-1:0]  LVL_RST  = 6'h12;

  // Bit positions
  localparam int FB_RXE  = 4;
  localparam int FB_TXF  = 5;
  localparam int FB_RXF  = 6;
  localparam int FB_TXE  = 7;
  localparam int IB_RX   = 4;
  localparam int IB_TX   = 5;
  localparam int LINE_QEN = 4;
  localparam int CTRL_FULLSET = 4;
endpackage

// File: rtl/uart_fe_idrom.sv
module uart_fe_idrom (
  input  logic [2:0] idx,
  output logic [7:0] id_byte
);
  always_comb begin
    case (idx)
      3'd0:    id_byte = 8'h11;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end
endmodule

// File: rtl/uart_fe_rxq.sv
// Receive ring; DEPTH must be a power of two so pointers wrap naturally.
module uart_fe_rxq #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qen,
  input  logic             push_valid,
  input  logic [7:0]       push_byte,
  output logic             push_ready,
  output logic             push_fire,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] cap;
  logic             pop_fire;

  assign cap        = qen ? CNT_W'(DEPTH) : CNT_W'(1);
  assign push_ready = (count < cap);
  assign push_fire  = push_valid & push_ready;
  assign pop_fire   = pop & (count != '0);
  assign head       = mem[rd_ptr];
  assign wr_ptr     = rd_ptr + count[PTR_W-1:0];
  assign count_nxt  = count + CNT_W'(push_fire) - CNT_W'(pop_fire);

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_fire) rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count_nxt;
    end
  end
endmodule

// File: rtl/uart_fe_status.sv
module uart_fe_status #(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_fire,
  input  logic             pop_evt,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             full_on_push,
  input  logic             tx_set,
  input  logic             clr_we,
  input  logic             clr_rx,
  input  logic             clr_tx,
  input  logic             mask_rx_nxt,
  input  logic             mask_tx_nxt,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             raw_rx,
  output logic             raw_tx,
  output logic             irq
);
  logic empty_d, full_d, rx_d, tx_d;

  always_comb begin
    empty_d = rx_empty;
    full_d  = rx_full;
    rx_d    = raw_rx;
    tx_d    = raw_tx;
    if (clr_we) begin
      rx_d = rx_d & ~clr_rx;
      tx_d = tx_d & ~clr_tx;
    end
    if (pop_evt) begin
      full_d = 1'b0;
      if (count_nxt == '0) empty_d = 1'b1;
      if (count_nxt == CNT_W'(TRIGGER - 1)) rx_d = 1'b0;
    end
    if (push_fire) begin
      empty_d = 1'b0;
      if (count_nxt == CNT_W'(DEPTH) || full_on_push) full_d = 1'b1;
      if (count_nxt == CNT_W'(TRIGGER)) rx_d = 1'b1;
    end
    if (tx_set) tx_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_empty <= 1'b1;
      rx_full  <= 1'b0;
      raw_rx   <= 1'b0;
      raw_tx   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rx_empty <= empty_d;
      rx_full  <= full_d;
      raw_rx   <= rx_d;
      raw_tx   <= tx_d;
      irq      <= (rx_d & mask_rx_nxt) | (tx_d & mask_tx_nxt);
    end
  end
endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              irq
);
  import uart_fe_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int WOFF_W = ADDR_W - 2;
  localparam int IDWIN_W = ADDR_W - 5;

  logic [WOFF_W-1:0] woff;
  logic              id_hit;
  logic [7:0]        id_byte;
  logic              wr_data, rd_data, wr_clr, wr_mask;

  logic [LPDIV_W-1:0] lpdiv_q;
  logic [IDIV_W-1:0]  idiv_q;
  logic [FDIV_W-1:0]  fdiv_q;
  logic [LINE_W-1:0]  line_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [MASK_W-1:0]  mask_q, mask_d;
  logic [DMA_W-1:0]   dma_q;

  logic              rxq_push_fire;
  logic [7:0]        rxq_head;
  logic [CNT_W-1:0]  rxq_count, rxq_count_nxt;
  logic              st_empty, st_full, st_raw_rx, st_raw_tx;
  logic [MASK_W-1:0] raw_vec;
  logic [7:0]        flag_byte;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign woff    = bus_addr[ADDR_W-1:2];
  assign id_hit  = &bus_addr[ADDR_W-1:5];
  assign wr_data = bus_wr && (woff == WOFF_W'(WO_DATA));
  assign rd_data = bus_rd && (woff == WOFF_W'(WO_DATA));
  assign wr_clr  = bus_wr && (woff == WOFF_W'(WO_ICLR));
  assign wr_mask = bus_wr && (woff == WOFF_W'(WO_MASK));
  assign mask_d  = wr_mask ? bus_wdata[MASK_W-1:0] : mask_q;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:IDIV_W], rxq_count};

  uart_fe_idrom u_idrom (
    .idx     (bus_addr[4:2]),
    .id_byte (id_byte)
  );

  uart_fe_rxq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_rxq (
    .clk        (clk),
    .rst        (rst),
    .qen        (line_q[LINE_QEN]),
    .push_valid (rx_valid),
    .push_byte  (rx_byte),
    .push_ready (rx_ready),
    .push_fire  (rxq_push_fire),
    .pop        (rd_data),
    .head       (rxq_head),
    .count      (rxq_count),
    .count_nxt  (rxq_count_nxt)
  );

  uart_fe_status #(.DEPTH(DEPTH), .TRIGGER(TRIGGER), .CNT_W(CNT_W)) u_status (
    .clk          (clk),
    .rst          (rst),
    .push_fire    (rxq_push_fire),
    .pop_evt      (rd_data),
    .count_nxt    (rxq_count_nxt),
    .full_on_push (ctrl_q[CTRL_FULLSET]),
    .tx_set       (wr_data),
    .clr_we       (wr_clr),
    .clr_rx       (bus_wdata[IB_RX]),
    .clr_tx       (bus_wdata[IB_TX]),
    .mask_rx_nxt  (mask_d[IB_RX]),
    .mask_tx_nxt  (mask_d[IB_TX]),
    .rx_empty     (st_empty),
    .rx_full      (st_full),
    .raw_rx       (st_raw_rx),
    .raw_tx       (st_raw_tx),
    .irq          (irq)
  );

  // Configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      lpdiv_q <= '0;
      idiv_q  <= '0;
      fdiv_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= CTRL_RST;
      lvl_q   <= LVL_RST;
      mask_q  <= '0;
      dma_q   <= '0;
    end else begin
      mask_q <= mask_d;
      if (bus_wr) begin
        case (woff)
          WOFF_W'(WO_LPDIV): lpdiv_q <= bus_wdata[LPDIV_W-1:0];
          WOFF_W'(WO_IDIV):  idiv_q  <= bus_wdata[IDIV_W-1:0];
          WOFF_W'(WO_FDIV):  fdiv_q  <= bus_wdata[FDIV_W-1:0];
          WOFF_W'(WO_LINE):  line_q  <= bus_wdata[LINE_W-1:0];
          WOFF_W'(WO_CTRL):  ctrl_q  <= bus_wdata[CTRL_W-1:0];
          WOFF_W'(WO_LVL):   lvl_q   <= bus_wdata[LVL_W-1:0];
          WOFF_W'(WO_DMA):   dma_q   <= bus_wdata[DMA_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // Transmit pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= wr_data;
      if (wr_data) tx_byte <= bus_wdata[7:0];
    end
  end

  always_comb begin
    raw_vec         = '0;
    raw_vec[IB_RX]  = st_raw_rx;
    raw_vec[IB_TX]  = st_raw_tx;
    flag_byte       = '0;
    flag_byte[FB_TXE] = 1'b1;
    flag_byte[FB_RXF] = st_full;
    flag_byte[FB_TXF] = 1'b0;
    flag_byte[FB_RXE] = st_empty;
  end

  always_comb begin
    rd_mux = '0;
    if (id_hit) begin
      rd_mux = DATA_W'(id_byte);
    end else begin
      case (woff)
        WOFF_W'(WO_DATA):  rd_mux = DATA_W'(rxq_head);
        WOFF_W'(WO_FLAG):  rd_mux = DATA_W'(flag_byte);
        WOFF_W'(WO_LPDIV): rd_mux = DATA_W'(lpdiv_q);
        WOFF_W'(WO_IDIV):  rd_mux = DATA_W'(idiv_q);
        WOFF_W'(WO_FDIV):  rd_mux = DATA_W'(fdiv_q);
        WOFF_W'(WO_LINE):  rd_mux = DATA_W'(line_q);
        WOFF_W'(WO_CTRL):  rd_mux = DATA_W'(ctrl_q);
        WOFF_W'(WO_LVL):   rd_mux = DATA_W'(lvl_q);
        WOFF_W'(WO_MASK):  rd_mux = DATA_W'(mask_q);
        WOFF_W'(WO_RAW):   rd_mux = DATA_W'(raw_vec);
        WOFF_W'(WO_MSTAT): rd_mux = DATA_W'(raw_vec & mask_q);
        WOFF_W'(WO_DMA):   rd_mux = DATA_W'(dma_q);
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_rvalid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic              flag_empty,
  input logic              raw_rx,
  input logic              raw_tx,
  input logic              mask_rx,
  input logic              mask_tx
);
  // R3: stored count never exceeds the ring size
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R3: a full ring refuses input
  p_full_refuse_r3: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !rx_ready);

  // R5: empty flag tracks the stored count
  p_empty_flag_r5: assert property (@(posedge clk) disable iff (rst)
    flag_empty == (count == '0));

  // R7: a transmit pulse only follows a data write
  p_tx_cause_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_wr && (bus_addr[ADDR_W-1:2] == '0)));

  // R9: combined interrupt agrees with raw status and mask
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    irq == ((raw_rx & mask_rx) | (raw_tx & mask_tx)));

  // R12: read strobe answered one cycle later
  p_rvalid_follow_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_rvalid_cause_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));
endmodule

bind uart_fe_top uart_fe_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .irq        (irq),
  .count      (rxq_count),
  .flag_empty (st_empty),
  .raw_rx     (st_raw_rx),
  .raw_tx     (st_raw_tx),
  .mask_rx    (mask_q[4]),
  .mask_tx    (mask_q[5])
);

// File: tb/test_uart_fe_top.sv
`timescale 1ns/1ps
module test_uart_fe_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          use_q[$];
  string       tag_q[$];
  logic [7:0]  txe_q[$];

  always #(CLK_NS/2) clk = ~clk;

  uart_fe_top i_uart_fe_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: drains scoreboards half a cycle after each result edge
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rvalid) begin
        if (exp_q.size() == 0) check("R12 unexpected rvalid", 32'd1, 32'd0);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic bit u = use_q.pop_front();
          automatic string t = tag_q.pop_front();
          if (u) check(t, bus_rdata, e);
        end
      end
      if (tx_valid) begin
        if (txe_q.size() == 0) check("R7 unexpected tx pulse", 32'd1, 32'd0);
        else check("R7 tx byte", {24'b0, tx_byte}, {24'b0, txe_q.pop_front()});
      end
    end
  end

  task automatic wr(int off, logic [31:0] val);
    @(negedge clk);
    bus_addr = 12'(off * 4); bus_wdata = val; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_raw(logic [11:0] baddr, logic [31:0] exp, bit use_it, string tag);
    @(negedge clk);
    exp_q.push_back(exp); use_q.push_back(use_it); tag_q.push_back(tag);
    bus_addr = baddr; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(int off, logic [31:0] exp, string tag);
    rd_raw(12'(off * 4), exp, 1'b1, tag);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_write(logic [31:0] val);
    txe_q.push_back(val[7:0]);
    wr(0, val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] idv [8];
    idv = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'd0);
    rd(6, 32'h90, "R1 flags reset");
    rd(12, 32'h300, "R1 control reset");
    rd(13, 32'h12, "R1 level select reset");
    rd(15, 32'h0, "R1 raw status reset");

    // R12 explicit latency
    @(negedge clk);
    exp_q.push_back(32'h12); use_q.push_back(1'b1); tag_q.push_back("R12 data");
    bus_addr = 12'(13 * 4); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R12 rvalid one cycle after read", {31'b0, bus_rvalid}, 32'd1);

    // R2 configuration storage
    wr(8, 32'h1AB);      rd(8, 32'hAB, "R2 low-power divisor");
    wr(9, 32'hFF1234);   rd(9, 32'h1234, "R2 integer divisor");
    wr(10, 32'hFF);      rd(10, 32'h3F, "R2 fractional divisor");
    wr(11, 32'h1EF);     rd(11, 32'hEF, "R2 line control");
    wr(12, 32'h10301);   rd(12, 32'h301, "R2 control");
    wr(13, 32'hFF);      rd(13, 32'h3F, "R2 level select");
    wr(14, 32'hFFFF);    rd(14, 32'h7FF, "R2 mask");
    wr(14, 32'h0);       rd(14, 32'h0, "R2 mask cleared");
    wr(18, 32'hF);       rd(18, 32'h7, "R2 DMA control");

    // R11 unmapped / read-only words
    rd(1, 32'h0, "R11 unmapped word 1");
    rd(63, 32'h0, "R11 unmapped word 63");
    wr(6, 32'hFF);       rd(6, 32'h90, "R11 flags write ignored");
    wr(15, 32'h30);      rd(15, 32'h0, "R11 raw write ignored");

    // R10 identification window
    for (int i = 0; i < 8; i++)
      rd_raw(12'hFE0 + 12'(i * 4), {24'b0, idv[i]}, 1'b1, "R10 id byte");

    // Single holding register (line control bit 4 = 0)
    send(8'h41);
    check("R3 ready low with one byte, queue disabled", {31'b0, rx_ready}, 32'd0);
    rd(6, 32'h80, "R5 flags after push");
    rd(15, 32'h10, "R6 raw rx set");
    rd(0, 32'h41, "R4 data");
    rd(6, 32'h90, "R5 flags after pop");
    rd(15, 32'h0, "R6 raw rx cleared");

    // R9 masking of receive interrupt
    wr(14, 32'h10);
    send(8'h42);
    check("R9 irq with rx masked in", {31'b0, irq}, 32'd1);
    rd(16, 32'h10, "R9 masked status");
    rd(0, 32'h42, "R4 data 2");
    check("R9 irq after pop", {31'b0, irq}, 32'd0);

    // R7 transmit, R8 clear
    tx_write(32'h1C5);
    rd(15, 32'h20, "R7 raw tx set");
    check("R9 irq tx not masked in", {31'b0, irq}, 32'd0);
    wr(14, 32'h30);
    check("R9 irq tx masked in", {31'b0, irq}, 32'd1);
    rd(16, 32'h20, "R9 masked tx");
    wr(17, 32'h20);
    rd(15, 32'h0, "R8 raw after clear");
    check("R8 irq after clear", {31'b0, irq}, 32'd0);

    // Queue enabled: 16 deep with wrap
    wr(11, 32'h10);
    for (int i = 0; i < 3; i++) send(8'(8'h90 + i));
    for (int i = 0; i < 3; i++) rd(0, 32'(8'h90 + i), "R4 pre-wrap order");
    for (int i = 0; i < 16; i++) begin
      check("R3 ready while not full", {31'b0, rx_ready}, 32'd1);
      send(8'(i * 3 + 1));
    end
    check("R3 ready low at 16", {31'b0, rx_ready}, 32'd0);
    rd(6, 32'hC0, "R5 full flag at 16");
    rd(0, 32'd1, "R4 oldest across wrap");
    rd(6, 32'h80, "R5 full cleared by read");
    for (int i = 1; i < 16; i++) rd(0, 32'(i * 3 + 1), "R4 order across wrap");
    rd(6, 32'h90, "R5 empty after drain");
    rd(15, 32'h0, "R6 rx cleared after drain");

    // R4 read when empty removes nothing
    rd_raw(12'h000, 32'h0, 1'b0, "R4 empty read");
    rd(6, 32'h90, "R4 flags after empty read");
    send(8'h66);
    rd(0, 32'h66, "R4 data after empty read");

    // R5 full set by control bit 4
    wr(12, 32'h310);
    send(8'h5A);
    rd(6, 32'hC0, "R5 full via control bit 4");
    rd(0, 32'h5A, "R4 data with control bit 4");
    rd(6, 32'h90, "R5 flags after read");
    wr(12, 32'h301);

    // R8 clear receive interrupt while data remains
    send(8'h77);
    wr(17, 32'h10);
    rd(15, 32'h0, "R8 rx cleared by write");
    rd(0, 32'h77, "R8 data kept");
    rd(6, 32'h90, "R5 flags final");

    repeat (4) @(negedge clk);
    check("R12 read scoreboard drained", 32'(exp_q.size()), 32'd0);
    check("R7 tx scoreboard drained", 32'(txe_q.size()), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule